// File: doc/BRIEF.md
# Circular DMA Transfer Counter

This block counts the four-byte DMA transfers of one audio stream direction that runs through a circular buffer in memory. Software programs a base count equal to the buffer length in bytes divided by four, minus one. While the channel is enabled, each transfer strobe counts the current count down by one. The strobe that arrives after the count has already reached zero reloads the count from the base value and raises a sticky interrupt request. Every pass through the buffer is therefore base+1 transfers long.

A small register port gives access to the base count, the current count and an interrupt status bit. Writing the base count also copies the value into the current count. The count registers can only be changed while the channel is disabled. The status bit is cleared by writing a one to it.

Top module: `dma_wrap_counter`

## Requirements
- R1: After reset the base count, the current count and the interrupt are all zero.
- R2: A write to address 0 (base count) while disabled loads the value into both the base count and the current count.
- R3: A write to address 0 or address 1 while `enable` is high is ignored, and the base and current counts keep their values.
- R4: While `enable` is high, each `xfer` strobe with a nonzero current count lowers it by one. Strobes that arrive while `enable` is low leave the count frozen, and counting resumes from that value once `enable` returns.
- R5: An enabled strobe that arrives while the current count is zero loads the base count into the current count without a decrement, and sets the interrupt in the same cycle.
- R6: With base count N, the interrupt is raised on every (N+1)-th enabled strobe.
- R7: Address 1 reads the current count. While disabled, a write to address 1 sets the current count and leaves the base count unchanged.
- R8: The interrupt stays set until a write to address 2 with data bit 0 equal to 1. A write to address 2 with bit 0 equal to 0 has no effect. If a wrap and a clear occur in the same cycle, the interrupt stays set. Clearing works whether or not `enable` is high.
- R9: Address 2 reads the interrupt in bit 0, with all other bits zero. Address 0 reads the base count. The `irq` output equals the status bit.
- R10: With a base count of zero, every enabled strobe wraps and the current count stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| enable | input | 1 | Channel enable; counting allowed, count writes blocked |
| xfer | input | 1 | One-cycle strobe per completed four-byte DMA transfer |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 base, 1 current, 2 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register (combinational) |
| irq | output | 1 | Sticky interrupt request |

## Verification
The main function is driven with several patterns: plain decrement runs, strobes while disabled, and wraps at a nonzero base. These tell apart counting, freezing and reload. A zero base count tells apart a design that reloads from one that wraps through all ones. A strobe that coincides with a clear of the interrupt tells apart set-priority from clear-priority. Count writes attempted while enabled show whether gating is in place, and a write of zero to the status register shows whether the clear looks at the data bit. A run with base 4 over three passes confirms that the interrupt period is base+1 strobes.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  typedef enum logic [1:0] {
    SEL_BASE = 2'd0,
    SEL_CUR  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/dwc_rst_sync.sv
module dwc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sh_q[STAGES-1];
endmodule

// File: rtl/dwc_count_core.sv
module dwc_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             xfer,
  input  logic             ld_base,
  input  logic             ld_cur,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] base_q,
  output logic [CNT_W-1:0] cur_q,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             step;
  logic             cur_zero;
  logic             base_en;
  logic             curw_en;
  logic             cur_en;
  logic [CNT_W-1:0] base_d;
  logic [CNT_W-1:0] cur_d;

  always_comb begin
    step     = enable & xfer;
    cur_zero = (cur_q == '0);
    wrap     = step & cur_zero;
    base_en  = ld_base & ~enable;
    curw_en  = ld_cur & ~enable;
    cur_en   = base_en | curw_en | step;
    base_d   = wdata;
    if (base_en | curw_en) cur_d = wdata;
    else if (wrap)         cur_d = base_q;
    else                   cur_d = cur_q - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= '0;
    else if (cur_en) cur_q <= cur_d;
  end

  // R4: an enabled strobe lowers a nonzero count by one
  p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && xfer && cur_q != '0) |=> (cur_q == $past(cur_q) - ONE));

  // R4: with no strobe and no write the count holds
  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(enable && xfer) && !((ld_base || ld_cur) && !enable)) |=> $stable(cur_q));

  // R5: a strobe at zero reloads from base
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && xfer && cur_q == '0) |=> (cur_q == $past(base_q)));

  // R3: base never changes while enabled
  p_base_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable(base_q));

  // R2: a base load copies into current
  p_base_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_base && !enable) |=> (cur_q == base_q));
endmodule

// File: rtl/dwc_irq_flag.sv
module dwc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag_q
);
  logic en;
  logic d;

  always_comb begin
    en = set | clr;
    d  = set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  flag_q <= 1'b0;
    else if (en) flag_q <= d;
  end

  // R8: set stays set unless cleared
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  // R8: set wins over a coincident clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);

  // R8: clear without set drops the flag
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag_q);
endmodule

// File: rtl/dma_wrap_counter.sv
module dma_wrap_counter #(
  parameter int CNT_W      = 16,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             xfer,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  import dwc_pkg::*;

  logic             rst_n_s;
  logic             ld_base;
  logic             ld_cur;
  logic             irq_clr;
  logic             wrap;
  logic [CNT_W-1:0] base_q;
  logic [CNT_W-1:0] cur_q;
  reg_sel_e         sel;

  dwc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  always_comb begin
    sel     = reg_sel_e'(reg_addr);
    ld_base = reg_wr & (sel == SEL_BASE);
    ld_cur  = reg_wr & (sel == SEL_CUR);
    irq_clr = reg_wr & (sel == SEL_STAT) & reg_wdata[0];
  end

  dwc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .enable  (enable),
    .xfer    (xfer),
    .ld_base (ld_base),
    .ld_cur  (ld_cur),
    .wdata   (reg_wdata),
    .base_q  (base_q),
    .cur_q   (cur_q),
    .wrap    (wrap)
  );

  dwc_irq_flag u_irq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .set    (wrap),
    .clr    (irq_clr),
    .flag_q (irq)
  );

  always_comb begin
    unique case (sel)
      SEL_BASE: reg_rdata = base_q;
      SEL_CUR:  reg_rdata = cur_q;
      SEL_STAT: reg_rdata = {{(CNT_W-1){1'b0}}, irq};
      default:  reg_rdata = '0;
    endcase
  end

  // R5: a wrap raises the interrupt and lands the count on base
  p_wrap_irq_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (enable && xfer && cur_q == '0) |=> (irq && cur_q == base_q));

  // R3: a count write while enabled changes nothing
  p_wr_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (enable && reg_wr && reg_addr != 2'd2 && !xfer) |=> $stable(cur_q));
endmodule

// File: tb/sim_dma_wrap_counter.sv
module sim_dma_wrap_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        xfer = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dma_wrap_counter u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .xfer(xfer),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // {en, wr, xf, addr[1:0], wdata[15:0], exp_cur[15:0], exp_irq, req[3:0]}
  localparam int NV = 18;
  localparam logic [41:0] VEC [NV] = '{
    {1'b0,1'b1,1'b0,2'd0,16'd3,16'd3,1'b0,4'd2},  // R2 base load copies
    {1'b1,1'b1,1'b0,2'd0,16'd9,16'd3,1'b0,4'd3},  // R3 base write ignored
    {1'b1,1'b0,1'b1,2'd0,16'd0,16'd2,1'b0,4'd4},  // R4 decrement
    {1'b1,1'b0,1'b1,2'd0,16'd0,16'd1,1'b0,4'd4},
    {1'b1,1'b0,1'b1,2'd0,16'd0,16'd0,1'b0,4'd4},
    {1'b0,1'b0,1'b1,2'd0,16'd0,16'd0,1'b0,4'd4},  // R4 frozen
    {1'b1,1'b0,1'b1,2'd0,16'd0,16'd3,1'b1,4'd5},  // R5 wrap
    {1'b1,1'b1,1'b0,2'd2,16'd1,16'd3,1'b0,4'd8},  // R8 clear while enabled
    {1'b1,1'b0,1'b1,2'd0,16'd0,16'd2,1'b0,4'd4},  // R4 resumes from base
    {1'b0,1'b1,1'b0,2'd1,16'd1,16'd1,1'b0,4'd7},  // R7 current write
    {1'b1,1'b0,1'b1,2'd0,16'd0,16'd0,1'b0,4'd4},
    {1'b1,1'b1,1'b1,2'd2,16'd1,16'd3,1'b1,4'd8},  // R8 set beats clear
    {1'b0,1'b1,1'b0,2'd2,16'd0,16'd3,1'b1,4'd8},  // R8 zero write no effect
    {1'b0,1'b1,1'b0,2'd2,16'd1,16'd3,1'b0,4'd8},  // R8 clear
    {1'b0,1'b1,1'b0,2'd0,16'd0,16'd0,1'b0,4'd10}, // R10 base zero
    {1'b1,1'b0,1'b1,2'd0,16'd0,16'd0,1'b1,4'd10}, // R10 wrap each strobe
    {1'b1,1'b1,1'b1,2'd2,16'd1,16'd0,1'b1,4'd10},
    {1'b1,1'b1,1'b0,2'd1,16'd5,16'd0,1'b1,4'd3}   // R3 current write ignored
  };

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic read(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  // drive at negedge, one edge, then read back
  task automatic step(input logic en, input logic wr, input logic xf,
                      input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    enable = en; reg_wr = wr; xfer = xf; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_wr = 1'b0; xfer = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    string rq;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    read(2'd0, v); check("R1", "base", v, 16'd0);
    read(2'd1, v); check("R1", "cur", v, 16'd0);
    read(2'd2, v); check("R1", "status", v, 16'd0);
    check("R1", "irq pin", {15'd0, irq}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] e;
      e = VEC[i];
      rq = $sformatf("R%0d", e[3:0]);
      step(e[41], e[40], e[39], e[38:37], e[36:21]);
      read(2'd1, v); check(rq, $sformatf("vec %0d cur", i), v, e[20:5]);
      read(2'd2, v); check(rq, $sformatf("vec %0d status", i), v, {15'd0, e[4]});
      check(rq, $sformatf("vec %0d irq pin", i), {15'd0, irq}, {15'd0, e[4]});
      if (i == 1) begin
        read(2'd0, v); check("R3", "base after gated write", v, 16'd3);
      end
      if (i == 9) begin
        read(2'd0, v); check("R7", "base untouched by cur write", v, 16'd3);
      end
    end

    // R9 base readback
    step(1'b0, 1'b1, 1'b0, 2'd2, 16'hFFFF);
    step(1'b0, 1'b1, 1'b0, 2'd0, 16'd4);
    read(2'd0, v); check("R9", "base readback", v, 16'd4);
    read(2'd2, v); check("R9", "status cleared, upper bits zero", v, 16'd0);

    // R6 period base+1 over three passes
    for (int k = 1; k <= 15; k++) begin
      step(1'b1, 1'b0, 1'b1, 2'd0, 16'd0);
      check("R6", $sformatf("irq after strobe %0d", k), {15'd0, irq},
            {15'd0, (k % 5 == 0)});
      if (irq) step(1'b1, 1'b1, 1'b0, 2'd2, 16'd1);
    end
    read(2'd1, v); check("R6", "cur back at base", v, 16'd4);

    // R1 reset mid-run
    @(negedge clk) rst_n = 1'b0;
    #1;
    read(2'd0, v); check("R1", "base in reset", v, 16'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    read(2'd1, v); check("R1", "cur after reset", v, 16'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule